// File: doc/BRIEF.md
# Programmable Minimum-Width Glitch Filter

This block conditions a single asynchronous input before internal logic uses it. The raw pin is first sampled by a chain of flip-flops on the block clock, which lowers the odds of a metastable value spreading further. The settled sample then goes to a width qualifier. The qualifier accepts a new level only after that level has held for a programmable number of consecutive clock cycles. A register holds that cycle count, and it can be rewritten at run time to retune how much noise is rejected. The block has no data stream, so it has no valid/ready handshake. Every pin is plain control or status.

The block drives a filtered level and two single-cycle event strobes, one for each direction of change. A pulse narrower than one clock period may fall between two sampling edges and never be seen. That is expected behaviour, not a fault. The synchronizer depth is a parameter from 2 to 8 stages.

Top module: `glitch_qual_top`

## Requirements
- R1: While `rst_n` is low and on its release, `level_out` equals the `RST_LEVEL` parameter (default 0), both strobes are 0, and `thr_cur` equals `THR_RESET` (default 4).
- R2: With an effective threshold of 1, a change on `async_in` that is set up before clock edge 1 appears on `level_out` after edge `SYNC_STAGES`+1 (4 edges with the default 3 stages).
- R3: With threshold T ≥ 1, `level_out` takes the synchronized value only after that value has differed from `level_out` on T consecutive comparison edges. A held input change appears after edge `SYNC_STAGES`+T. An excursion lasting fewer than T cycles leaves `level_out` unchanged.
- R4: When the synchronized input returns to the `level_out` value before T differing samples have been seen, the count restarts from zero. Short excursions separated by gaps never add up to T.
- R5: A threshold value of 0 behaves exactly like a value of 1: the synchronized input passes with no extra qualification delay.
- R6: `rise_pulse` is high for exactly the first cycle in which `level_out` is 1 after being 0, and is 0 at all other times.
- R7: `fall_pulse` is high for exactly the first cycle in which `level_out` is 0 after being 1, and is 0 at all other times. The two strobes are never high together.
- R8: When `thr_wr_en` is high at a clock edge, `thr_cur` takes `thr_wr_data` at that edge, and `thr_cur` is otherwise stable. The new value governs comparisons from the next edge on. The write by itself does not change `level_out`.
- R9: A pulse on `async_in` that starts and ends between two rising clock edges has no effect on `level_out` or on the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples the raw input |
| rst_n | input | 1 | Asynchronous reset, active low |
| async_in | input | 1 | Raw asynchronous input level |
| thr_wr_en | input | 1 | Write strobe for the threshold register |
| thr_wr_data | input | CNT_W | Threshold value to be written |
| thr_cur | output | CNT_W | Current threshold register contents |
| level_out | output | 1 | Filtered, qualified level |
| rise_pulse | output | 1 | One-cycle strobe on a low-to-high filtered change |
| fall_pulse | output | 1 | One-cycle strobe on a high-to-low filtered change |

## Verification
The properties assume that `rst_n` is held low across at least one rising edge before release. They also assume that `thr_wr_en` and `thr_wr_data` are driven to known values whenever reset is inactive.

The stimulus sets `async_in`, `thr_wr_en` and `thr_wr_data` only at falling edges. The one exception is the deliberate sub-period pulse, which rises and falls between two rising edges. The random runs keep thresholds between 0 and 7, so every qualification window closes inside the run, and they hold `rst_n` high throughout.

// File: rtl/glf_pkg.sv
package glf_pkg;
  localparam int unsigned SYNC_MIN = 2;
  localparam int unsigned SYNC_MAX = 8;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10
  } edge_e;

  function automatic int unsigned clamp_stages(input int unsigned req);
    if (req < SYNC_MIN) return SYNC_MIN;
    if (req > SYNC_MAX) return SYNC_MAX;
    return req;
  endfunction
endpackage

// File: rtl/glf_sync.sv
module glf_sync #(
  parameter int unsigned STAGES  = 3,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int unsigned DEPTH = glf_pkg::clamp_stages(STAGES);

  logic [DEPTH-1:0] chain;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[DEPTH-1];
endmodule

// File: rtl/glf_thr_reg.sv
module glf_thr_reg #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_THR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] thr
);
  localparam logic [CNT_W-1:0] RST_CODE = CNT_W'(RST_THR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     thr <= RST_CODE;
    else if (wr_en) thr <= wr_data;
  end
endmodule

// File: rtl/glf_qual.sv
module glf_qual #(
  parameter int unsigned CNT_W   = 8,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample,
  input  logic [CNT_W-1:0] thr,
  output logic             level
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_inc;
  logic [CNT_W-1:0] eff_thr;
  logic             differs;
  logic             reached;

  always_comb begin
    eff_thr = (thr == '0) ? ONE : thr;
    differs = sample ^ level;
    run_inc = run_q + ONE;
    reached = (run_inc >= eff_thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      level <= RST_VAL;
    end else if (!differs) begin
      run_q <= '0;
    end else if (reached) begin
      run_q <= '0;
      level <= sample;
    end else begin
      run_q <= run_inc;
    end
  end
endmodule

// File: rtl/glf_edge.sv
module glf_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise,
  output logic fall
);
  import glf_pkg::*;

  logic  prev_q;
  edge_e kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= level;
  end

  always_comb begin
    kind = EDGE_NONE;
    if (level && !prev_q)      kind = EDGE_RISE;
    else if (!level && prev_q) kind = EDGE_FALL;
  end

  assign rise = (kind == EDGE_RISE);
  assign fall = (kind == EDGE_FALL);
endmodule

// File: rtl/glitch_qual_top.sv
module glitch_qual_top #(
  parameter int unsigned SYNC_STAGES = 3,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned THR_RESET   = 4,
  parameter logic        RST_LEVEL   = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             async_in,
  input  logic             thr_wr_en,
  input  logic [CNT_W-1:0] thr_wr_data,
  output logic [CNT_W-1:0] thr_cur,
  output logic             level_out,
  output logic             rise_pulse,
  output logic             fall_pulse
);
  logic synced;

  glf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(RST_LEVEL)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(async_in), .q(synced)
  );

  glf_thr_reg #(.CNT_W(CNT_W), .RST_THR(THR_RESET)) u_thr (
    .clk(clk), .rst_n(rst_n), .wr_en(thr_wr_en), .wr_data(thr_wr_data), .thr(thr_cur)
  );

  glf_qual #(.CNT_W(CNT_W), .RST_VAL(RST_LEVEL)) u_qual (
    .clk(clk), .rst_n(rst_n), .sample(synced), .thr(thr_cur), .level(level_out)
  );

  glf_edge #(.RST_VAL(RST_LEVEL)) u_edge (
    .clk(clk), .rst_n(rst_n), .level(level_out), .rise(rise_pulse), .fall(fall_pulse)
  );
endmodule

// File: rtl/glitch_qual_chk.sv
module glitch_qual_chk #(
  parameter int unsigned CNT_W     = 8,
  parameter logic        RST_LEVEL = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             thr_wr_en,
  input logic [CNT_W-1:0] thr_wr_data,
  input logic [CNT_W-1:0] thr_cur,
  input logic             level_out,
  input logic             rise_pulse,
  input logic             fall_pulse
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> (level_out == RST_LEVEL) && !rise_pulse && !fall_pulse);

  assert_rise_marks_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |-> level_out && !$past(level_out));

  assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !rise_pulse);

  assert_fall_marks_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fall_pulse |-> !level_out && $past(level_out));

  assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_pulse && fall_pulse));

  assert_change_strobed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (level_out != $past(level_out)) |-> (rise_pulse || fall_pulse));

  assert_thr_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr_en |=> thr_cur == $past(thr_wr_data));

  assert_thr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_wr_en |=> $stable(thr_cur));
endmodule

bind glitch_qual_top glitch_qual_chk #(.CNT_W(CNT_W), .RST_LEVEL(RST_LEVEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .thr_wr_en(thr_wr_en), .thr_wr_data(thr_wr_data),
  .thr_cur(thr_cur), .level_out(level_out), .rise_pulse(rise_pulse), .fall_pulse(fall_pulse)
);

// File: tb/glitch_qual_top_test.sv
module glitch_qual_top_test;
  localparam int S  = 3;
  localparam int CW = 8;
  localparam int TR = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          async_in = 1'b0;
  logic          thr_wr_en = 1'b0;
  logic [CW-1:0] thr_wr_data = '0;
  logic [CW-1:0] thr_cur;
  logic          level_out, rise_pulse, fall_pulse;

  int n_cmp = 0;
  int n_bad = 0;

  logic m_sync [S];
  logic m_lvl, m_prev;
  int   m_cnt, m_thr;

  glitch_qual_top #(.SYNC_STAGES(S), .CNT_W(CW), .THR_RESET(TR), .RST_LEVEL(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .async_in(async_in), .thr_wr_en(thr_wr_en),
    .thr_wr_data(thr_wr_data), .thr_cur(thr_cur), .level_out(level_out),
    .rise_pulse(rise_pulse), .fall_pulse(fall_pulse)
  );

  always #10 clk = ~clk;

  task automatic chk(input int act, input int exp, input string tag, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < S; i++) m_sync[i] = 1'b0;
    m_lvl = 1'b0; m_prev = 1'b0; m_cnt = 0; m_thr = TR;
  endtask

  task automatic model_edge(input logic v, input logic we, input int wd);
    int eff;
    logic n_lvl;
    int n_cnt;
    eff = (m_thr == 0) ? 1 : m_thr;
    n_lvl = m_lvl; n_cnt = 0;
    if (m_sync[S-1] != m_lvl) begin
      if (m_cnt + 1 >= eff) n_lvl = m_sync[S-1];
      else n_cnt = m_cnt + 1;
    end
    m_prev = m_lvl; m_lvl = n_lvl; m_cnt = n_cnt;
    for (int i = S-1; i > 0; i--) m_sync[i] = m_sync[i-1];
    m_sync[0] = v;
    if (we) m_thr = wd;
  endtask

  task automatic check_model(input string tag);
    chk(level_out, m_lvl, tag, "level");
    chk(rise_pulse, m_lvl & ~m_prev, "R6", "rise");
    chk(fall_pulse, ~m_lvl & m_prev, "R7", "fall");
    chk(thr_cur, m_thr, "R8", "thr");
  endtask

  task automatic step(input logic v, input logic we, input int wd, input string tag);
    async_in = v; thr_wr_en = we; thr_wr_data = CW'(wd);
    @(posedge clk);
    model_edge(v, we, wd);
    @(negedge clk);
    thr_wr_en = 1'b0;
    check_model(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; async_in = 1'b0; thr_wr_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(level_out, 0, "R1", "level in reset");
    model_reset();
    rst_n = 1'b1;
    chk(level_out, 0, "R1", "level");
    chk(rise_pulse, 0, "R1", "rise");
    chk(fall_pulse, 0, "R1", "fall");
    chk(thr_cur, TR, "R1", "thr");
  endtask

  task automatic settle(input logic v, input int n);
    for (int i = 0; i < n; i++) step(v, 1'b0, 0, "R3");
  endtask

  task automatic measure(input logic v, input int exp, input string tag);
    int n = 0;
    do begin
      step(v, 1'b0, 0, tag);
      n++;
    end while (level_out != v && n < 40);
    chk(n, exp, tag, "edges to change");
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int lows;
    int seen_fall;
    void'($urandom(32'h5eed_1234));
    model_reset();
    do_reset();

    // R2: threshold 0 -> bare synchronizer latency
    step(1'b0, 1'b1, 0, "R8");
    settle(1'b0, 4);
    measure(1'b1, S + 1, "R2");
    // R5: threshold 1 identical to threshold 0
    step(1'b1, 1'b1, 1, "R8");
    settle(1'b1, 4);
    measure(1'b0, S + 1, "R5");
    // R3: threshold 5 held change
    step(1'b0, 1'b1, 5, "R8");
    settle(1'b0, 4);
    measure(1'b1, S + 5, "R3");
    settle(1'b1, 4);
    // R3: excursion of 4 cycles rejected
    lows = 0;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 0, "R3");
    for (int i = 0; i < 10; i++) begin
      step(1'b1, 1'b0, 0, "R3");
      if (!level_out) lows++;
    end
    chk(lows, 0, "R3", "cycles low after short excursion");
    chk(level_out, 1, "R3", "level after short excursion");
    // R4: split excursions never accumulate
    lows = 0;
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 3; i++) begin step(1'b0, 1'b0, 0, "R4"); if (!level_out) lows++; end
      step(1'b1, 1'b0, 0, "R4"); if (!level_out) lows++;
    end
    for (int i = 0; i < 8; i++) begin step(1'b1, 1'b0, 0, "R4"); if (!level_out) lows++; end
    chk(lows, 0, "R4", "cycles low after split excursions");
    // R3/R7: excursion of exactly 5 passes
    seen_fall = 0;
    for (int i = 0; i < 5; i++) begin step(1'b0, 1'b0, 0, "R3"); if (fall_pulse) seen_fall++; end
    for (int i = 0; i < 12; i++) begin step(1'b1, 1'b0, 0, "R3"); if (fall_pulse) seen_fall++; end
    chk(seen_fall, 1, "R7", "fall strobes for width-5 excursion");
    chk(level_out, 1, "R3", "level restored");
    // R8: lower the threshold mid-count
    step(1'b0, 1'b1, 10, "R8");
    settle(1'b0, 20);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 0, "R8");
    step(1'b1, 1'b1, 2, "R8");
    chk(level_out, 0, "R8", "level on write edge");
    step(1'b1, 1'b0, 0, "R8");
    chk(level_out, 1, "R8", "level one edge after write");
    // R9: sub-period pulse
    step(1'b0, 1'b1, 1, "R8");
    settle(1'b0, 6);
    #2 async_in = 1'b1;
    #4 async_in = 1'b0;
    lows = 0;
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 1'b0, 0, "R9");
      if (level_out || rise_pulse) lows++;
    end
    chk(lows, 0, "R9", "cycles disturbed by sub-period pulse");

    // random mix, compared against the model every cycle
    for (int k = 0; k < 600; k++) begin
      logic v;
      int len;
      v = 1'($urandom_range(0, 1));
      len = $urandom_range(1, 9);
      for (int i = 0; i < len; i++) begin
        if ($urandom_range(0, 15) == 0) step(v, 1'b1, $urandom_range(0, 7), "R3");
        else step(v, 1'b0, 0, "R3");
      end
    end

    // reset again mid-activity
    step(1'b1, 1'b0, 0, "R3");
    do_reset();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule